// File: doc/BRIEF.md
# Signed Booth-Recoded Carry-Save Multiplier

This block multiplies two signed two's-complement operands of `N` bits each and returns the full `2N`-bit signed product. It needs `N` of at least 2.

Each bit position of the multiplier is recoded with radix-2 Booth recoding. The recoding looks at the current bit and the bit just below it, and treats the bit below position 0 as zero. The recoding gives each partial-product row one of three values: zero, the multiplicand, or its negation. The negated multiplicand comes from an invert-and-increment ripple chain that is one bit wider than the operand. Each row is sign-extended and shifted into place. Layers of word-wide 3:2 full-adder compressors then reduce the rows to a sum row and a carry row. A parallel-prefix carry-lookahead adder adds those two rows.

The product can be taken straight from the adder or through one output register. A parameter picks which. With the register, the block fits into a pipelined datapath such as a butterfly stage.

Top module: `booth_wallace_mul`

## Requirements
- R1: For every pair of signed operands, `product` equals the mathematical product of `md` and `mr`, written as a `2N`-bit two's-complement value.
- R2: When `mr` is all ones (value -1), `product` equals the `2N`-bit negation of `md`. The pair of `mr` bit 0 with the implicit zero below it selects the negated multiplicand, and every higher pair (11) selects a zero row.
- R3: When `md` is the most negative value -2^(N-1), the product is still exact. With both operands at that value, the product is +2^(2N-2).
- R4: When `md` is zero or `mr` is zero, `product` is zero.
- R5: For nonzero operands, bit `2N-1` of `product` equals the XOR of the two operand sign bits.
- R6: With `REG_OUT` = 1, `product` changes only on a rising clock edge, and it shows the result for the operands present at that edge.
- R7: With `REG_OUT` = 1, holding `rst_n` low forces `product` to zero, whatever the operands are.
- R8: When `mr` is 1, `product` equals `md` sign-extended to `2N` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| md | input | N | Signed multiplicand |
| mr | input | N | Signed multiplier (the operand that is recoded) |
| product | output | 2N | Signed product |

## Verification
The bench builds the block with `N` = 8 and the output register enabled. At that size all 65,536 operand pairs can be applied one per cycle, and each result is compared with a signed multiply computed in the bench. This sweep covers every recoding pattern and every corner. That includes the most negative multiplicand, the all-ones multiplier and the zero operands, and every sign combination. A short directed sequence around reset, and around the moment the operands change, covers the register's reset value and its one-cycle latency.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    typedef struct packed {
        logic nz;   // row is not zero
        logic neg;  // row takes the negated multiplicand
    } booth_ctl_t;

    // Rows that remain after one layer of 3:2 compression
    function automatic int rows_next(input int c);
        return 2 * (c / 3) + (c % 3);
    endfunction

    function automatic int rows_at(input int n, input int lv);
        int c;
        c = n;
        for (int k = 0; k < lv; k++) c = rows_next(c);
        return c;
    endfunction

    function automatic int tree_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 2) begin
            c = rows_next(c);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/bwm_negate.sv
module bwm_negate #(
    parameter int N = 8
) (
    input  logic [N-1:0] md,
    output logic [N:0]   neg_md
);
    // One bit wider, so that -(-2^(N-1)) can be represented
    logic [N:0] inv;
    logic [N:0] carry;

    assign inv      = ~{md[N-1], md};
    assign carry[0] = 1'b1;

    for (genvar i = 0; i <= N; i++) begin : g_rip
        assign neg_md[i] = inv[i] ^ carry[i];
        if (i < N) begin : g_c
            assign carry[i+1] = inv[i] & carry[i];
        end
    end
endmodule

// File: rtl/bwm_booth_enc.sv
module bwm_booth_enc
    import bwm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]           mr,
    output booth_ctl_t [N-1:0]     ctl
);
    logic [N:0] ext;
    assign ext = {mr, 1'b0};   // implicit zero below bit 0

    for (genvar i = 0; i < N; i++) begin : g_enc
        assign ctl[i].nz  = ext[i+1] ^ ext[i];
        assign ctl[i].neg = ext[i+1] & ~ext[i];
    end
endmodule

// File: rtl/bwm_ppgen.sv
module bwm_ppgen
    import bwm_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 2 * N
) (
    input  logic [N-1:0]       md,
    input  logic [N:0]         neg_md,
    input  booth_ctl_t [N-1:0] ctl,
    output logic [W-1:0]       rows [N]
);
    localparam int EXT = W - N - 1;

    logic [N:0] pos;
    assign pos = {md[N-1], md};

    for (genvar i = 0; i < N; i++) begin : g_row
        logic [N:0]   sel;
        logic [W-1:0] wide;
        assign sel     = ctl[i].nz ? (ctl[i].neg ? neg_md : pos) : '0;
        assign wide    = {{EXT{sel[N]}}, sel};
        assign rows[i] = wide << i;
    end
endmodule

// File: rtl/bwm_csa_tree.sv
module bwm_csa_tree
    import bwm_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 2 * N
) (
    input  logic [W-1:0] rows [N],
    output logic [W-1:0] sum_a,
    output logic [W-1:0] sum_b
);
    localparam int LV = tree_levels(N);

    logic [W-1:0] lvl [LV+1][N];

    for (genvar j = 0; j < N; j++) begin : g_in
        assign lvl[0][j] = rows[j];
    end

    for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
        localparam int C  = rows_at(N, lv);
        localparam int G  = C / 3;
        localparam int R  = C % 3;
        localparam int NC = rows_at(N, lv + 1);

        for (genvar g = 0; g < G; g++) begin : g_fa
            logic [W-1:0] a, b, c, maj;
            assign a   = lvl[lv][3*g];
            assign b   = lvl[lv][3*g+1];
            assign c   = lvl[lv][3*g+2];
            assign maj = (a & b) | (a & c) | (b & c);
            assign lvl[lv+1][2*g]   = a ^ b ^ c;
            assign lvl[lv+1][2*g+1] = {maj[W-2:0], 1'b0};
        end
        for (genvar r = 0; r < R; r++) begin : g_pass
            assign lvl[lv+1][2*G+r] = lvl[lv][3*G+r];
        end
        for (genvar j = NC; j < N; j++) begin : g_zero
            assign lvl[lv+1][j] = '0;
        end
    end

    assign sum_a = lvl[LV][0];
    assign sum_b = lvl[LV][1];
endmodule

// File: rtl/bwm_cla.sv
module bwm_cla #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int LG = $clog2(W);

    logic [W-1:0] gg [LG+1];
    logic [W-1:0] pp [LG+1];
    logic [W-1:0] half;

    assign half  = a ^ b;
    assign gg[0] = a & b;
    assign pp[0] = half;

    for (genvar k = 0; k < LG; k++) begin : g_pfx
        localparam int D = 1 << k;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= D) begin : g_op
                assign gg[k+1][i] = gg[k][i] | (pp[k][i] & gg[k][i-D]);
                assign pp[k+1][i] = pp[k][i] & pp[k][i-D];
            end else begin : g_cp
                assign gg[k+1][i] = gg[k][i];
                assign pp[k+1][i] = pp[k][i];
            end
        end
    end

    assign sum[0] = half[0];
    for (genvar i = 1; i < W; i++) begin : g_sum
        assign sum[i] = half[i] ^ gg[LG][i-1];
    end
endmodule

// File: rtl/booth_wallace_mul.sv
module booth_wallace_mul
    import bwm_pkg::*;
#(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   md,
    input  logic [N-1:0]   mr,
    output logic [2*N-1:0] product
);
    localparam int W = 2 * N;

    typedef struct packed {
        logic [W-1:0] product;
    } out_t;

    logic [N:0]         neg_md;
    booth_ctl_t [N-1:0] ctl;
    logic [W-1:0]       rows [N];
    logic [W-1:0]       sum_a, sum_b, sum;
    out_t               st_d;

    bwm_negate #(.N(N)) u_neg (
        .md     (md),
        .neg_md (neg_md)
    );

    bwm_booth_enc #(.N(N)) u_enc (
        .mr  (mr),
        .ctl (ctl)
    );

    bwm_ppgen #(.N(N), .W(W)) u_pp (
        .md     (md),
        .neg_md (neg_md),
        .ctl    (ctl),
        .rows   (rows)
    );

    bwm_csa_tree #(.N(N), .W(W)) u_tree (
        .rows  (rows),
        .sum_a (sum_a),
        .sum_b (sum_b)
    );

    bwm_cla #(.W(W)) u_cla (
        .a   (sum_a),
        .b   (sum_b),
        .sum (sum)
    );

    always_comb begin
        st_d         = '0;
        st_d.product = sum;
    end

    if (REG_OUT) begin : g_reg
        out_t st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign product = st_q.product;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign product    = st_d.product;
    end
endmodule

// File: rtl/bwm_check.sv
module bwm_check #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   md,
    input logic [N-1:0]   mr,
    input logic [2*N-1:0] product
);
    localparam int W = 2 * N;

    logic signed [W-1:0] ref_prod;
    logic        [W-1:0] md_ext;
    always_comb begin
        ref_prod = $signed({{N{md[N-1]}}, md}) * $signed({{N{mr[N-1]}}, mr});
        md_ext   = {{N{md[N-1]}}, md};
    end

    if (REG_OUT) begin : g_seq
        logic armed_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) armed_q <= 1'b0;
            else        armed_q <= 1'b1;
        end

        AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> product == $past(ref_prod));                                   // R1
        AST_NEG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(mr) == {N{1'b1}}) |-> product == W'(-$past(md_ext)));    // R2
        AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && ($past(md) == '0 || $past(mr) == '0)) |-> product == '0);      // R4
        AST_SIGN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(md) != '0 && $past(mr) != '0)
            |-> product[W-1] == ($past(md[N-1]) ^ $past(mr[N-1])));                   // R5
        AST_UNIT_MR: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(mr) == N'(1)) |-> product == $past(md_ext));             // R8
    end else begin : g_cmb
        AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            product == ref_prod);                                                      // R1
    end
endmodule

bind booth_wallace_mul bwm_check #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .md      (md),
    .mr      (mr),
    .product (product)
);

// File: tb/tb_booth_wallace_mul.sv
`timescale 1ns/1ps
module tb_booth_wallace_mul;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   md = '0;
    logic [N-1:0]   mr = '0;
    logic [W-1:0]   product;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    booth_wallace_mul #(.N(N), .REG_OUT(1'b1)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .md      (md),
        .mr      (mr),
        .product (product)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s md=%0d mr=%0d got=%h exp=%h", req,
                     $signed(md), $signed(mr), got, exp);
        end
    endtask

    function automatic logic [W-1:0] expect_of(input int a, input int b);
        int p;
        p = a * b;
        return p[W-1:0];
    endfunction

    initial begin
        // R7: reset holds product at zero with nonzero operands
        md = 8'd5;
        mr = 8'd7;
        repeat (3) @(posedge clk);
        #1 check("R7", product, '0);

        // R6: no change before the edge, new value after it
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #1 check("R6", product, expect_of(5, 7));
        @(negedge clk) begin md = 8'd3; mr = 8'hFB; end
        #1 check("R6", product, expect_of(5, 7));
        @(posedge clk) #1 check("R6", product, expect_of(3, -5));

        // R3 directed: both operands most negative
        @(negedge clk) begin md = 8'h80; mr = 8'h80; end
        @(posedge clk) #1 check("R3", product, 16'h4000);

        // Exhaustive sweep
        for (int a = -(1 << (N-1)); a < (1 << (N-1)); a++) begin
            for (int b = -(1 << (N-1)); b < (1 << (N-1)); b++) begin
                logic [W-1:0] e;
                string tag;
                @(negedge clk) begin md = N'(a); mr = N'(b); end
                @(posedge clk) #1;
                e = expect_of(a, b);
                if (a == -(1 << (N-1)))      tag = "R3";
                else if (a == 0 || b == 0)   tag = "R4";
                else if (b == -1)            tag = "R2";
                else if (b == 1)             tag = "R8";
                else                         tag = "R1";
                check(tag, product, e);
                if (a != 0 && b != 0)
                    check("R5", W'(product[W-1]), W'((a < 0) ^ (b < 0)));
            end
        end

        // R7: asserting reset again clears the register
        @(negedge clk) begin md = 8'h7F; mr = 8'h7F; rst_n = 1'b0; end
        #1 check("R7", product, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got=timeout exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule